// File: doc/BRIEF.md
# Paged CSR Window Address Decoder

This block connects a 32-bit register slave port with a 12-bit byte offset to an internal register space that is 16 bits wide. Bus offsets below 0xC00 reach the internal register with the same offset. The top quarter of the aperture, 0xC00 to 0xFFF, is a window. A page index held in a control register selects which 1 KiB page of the internal space the window shows. Software writes the page index first and then uses the window.

The block holds the control register. It checks every access for size and alignment and rejects the bad ones. It forms the internal offset and drives a behavioural word store. Each request gets exactly one response, one cycle later and in order. The control register also holds two path-enable bits, which are brought out as outputs.

Top module: `csr_page_decoder`

## Requirements
- R1: A bus offset below 0xC00 reaches internal offset equal to the bus offset. For example, bus 0x410 and window offset 0x010 with page 1 reach the same word.
- R2: The control register sits at bus word 0x808. Bits 18:13 hold the page index, bit 0 the slave-side PIO enable and bit 1 the link-side PIO enable. All other bits read as 0 and ignore writes. Control accesses never reach the store.
- R3: A bus offset at or above 0xC00 reaches internal offset {page[5:0], bus_offset[9:0]}.
- R4: A control write in one cycle changes the page used by a request in the very next cycle. Without a control write the page holds.
- R5: size_i encodes 0 = byte, 1 = halfword, 2 = word, 3 = illegal. An access with code 3, or with an address that is not a multiple of its size, is rejected. A rejected access raises err_o in its response cycle, returns rdata_o = 0 and changes neither the store nor the control register.
- R6: rvalid_o is high exactly in the cycle after each request and low otherwise. Byte lanes are selected by addr_i[1:0] and the size. A write changes only its lanes. A read returns its lanes in place, with the other lanes 0. A write response carries rdata_o = 0.
- R7: While rst_ni is low, the page resets to 0 and both enables reset to 0. The store resets to zero.
- R8: The store keeps 256 words. A word is selected by internal offset bits 11:10 and 7:2. The other offset bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Bus byte offset |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data on its byte lanes |
| rvalid_o | output | 1 | Response strobe |
| err_o | output | 1 | Rejected access, with rvalid_o |
| rdata_o | output | 32 | Read data |
| page_o | output | 6 | Current page index |
| axi_pio_en_o | output | 1 | Slave-side PIO enable |
| pex_pio_en_o | output | 1 | Link-side PIO enable |

## Verification
Two functions can fall on the same edge: a control write that changes the page, and a windowed access issued in the next cycle that must already decode with the new page. The bench provokes this by issuing page writes and window accesses back to back with no idle cycle. It judges each response against a model that updates the page at the write. The second overlap is a misaligned access to the control word itself. Here rejection must win over the control update, and this is judged by reading back the control word.

// File: rtl/csr_page_pkg.sv
package csr_page_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/csr_lane_check.sv
module csr_lane_check
  import csr_page_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic [1:0]      addr_lo_i,
  input  logic [1:0]      size_i,
  output logic            legal_o,
  output logic [BE_W-1:0] be_o
);
  acc_size_e sz;
  assign sz = acc_size_e'(size_i);

  always_comb begin
    legal_o = 1'b0;
    be_o    = '0;
    unique case (sz)
      SZ_BYTE: begin
        legal_o = 1'b1;
        be_o    = BE_W'(1) << addr_lo_i;
      end
      SZ_HALF: begin
        legal_o = ~addr_lo_i[0];
        be_o    = BE_W'(3) << {addr_lo_i[1], 1'b0};
      end
      SZ_WORD: begin
        legal_o = (addr_lo_i == 2'b00);
        be_o    = '1;
      end
      default: begin
        legal_o = 1'b0;
        be_o    = '0;
      end
    endcase
  end
endmodule

// File: rtl/csr_page_map.sv
module csr_page_map #(
  parameter int              ADDR_W   = 12,
  parameter int              PAGE_W   = 6,
  parameter int              WIN_W    = 10,
  parameter int              DATA_W   = 32,
  parameter int              PAGE_LSB = 13,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h808,
  localparam int             INT_W    = PAGE_W + WIN_W,
  localparam int             BE_W     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [INT_W-1:0]  int_off_o,
  output logic              ctrl_hit_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              axi_en_o,
  output logic              pex_en_o
);
  logic [PAGE_W-1:0] page_q;
  logic [1:0]        en_q;
  logic [DATA_W-1:0] bit_mask, merged;
  logic              in_window;

  assign in_window  = &addr_i[ADDR_W-1:WIN_W];
  assign ctrl_hit_o = (addr_i[ADDR_W-1:2] == CTRL_OFF[ADDR_W-1:2]);
  assign int_off_o  = in_window ? {page_q, addr_i[WIN_W-1:0]} : INT_W'(addr_i);

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[PAGE_LSB +: PAGE_W] = page_q;
    ctrl_rd_o[1:0] = en_q;
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_mask
    assign bit_mask[8*b +: 8] = {8{be_i[b]}};
  end

  assign merged = (ctrl_rd_o & ~bit_mask) | (wdata_i & bit_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      page_q <= merged[PAGE_LSB +: PAGE_W];
      en_q   <= merged[1:0];
    end
  end

  assign page_o   = page_q;
  assign axi_en_o = en_q[0];
  assign pex_en_o = en_q[1];

  // R4
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(page_o));
endmodule

// File: rtl/csr_reg_store.sv
module csr_reg_store #(
  parameter int INT_W   = 16,
  parameter int WIN_W   = 10,
  parameter int HI_BITS = 2,
  parameter int LO_BITS = 6,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = HI_BITS + LO_BITS,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  int_off_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              unused_bits;

  assign idx = {int_off_i[WIN_W +: HI_BITS], int_off_i[2 +: LO_BITS]};
  assign unused_bits = ^{int_off_i[INT_W-1:WIN_W+HI_BITS],
                         int_off_i[WIN_W-1:LO_BITS+2], int_off_i[1:0]};
  assign rdata_o = mem_q[idx];

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w][8*b +: 8] <= '0;
      end else if (we_i && be_i[b]) begin
        mem_q[idx][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/csr_page_decoder.sv
module csr_page_decoder #(
  parameter int ADDR_W  = 12,
  parameter int PAGE_W  = 6,
  parameter int WIN_W   = 10,
  parameter int DATA_W  = 32,
  parameter int HI_BITS = 2,
  parameter int LO_BITS = 6,
  localparam int INT_W  = PAGE_W + WIN_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              axi_pio_en_o,
  output logic              pex_pio_en_o
);
  logic              legal;
  logic [BE_W-1:0]   be;
  logic [INT_W-1:0]  int_off;
  logic              ctrl_hit;
  logic [DATA_W-1:0] ctrl_rd, store_rd, lane_mask, rd_sel;
  logic              ok, ctrl_wr, store_wr;
  logic              rvalid_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  csr_lane_check #(.BE_W(BE_W)) u_lane (
    .addr_lo_i(addr_i[1:0]),
    .size_i   (size_i),
    .legal_o  (legal),
    .be_o     (be)
  );

  assign ok       = req_i && legal;
  assign ctrl_wr  = ok && we_i && ctrl_hit;
  assign store_wr = ok && we_i && !ctrl_hit;

  csr_page_map #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .DATA_W(DATA_W)
  ) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (ctrl_wr),
    .wdata_i   (wdata_i),
    .be_i      (be),
    .int_off_o (int_off),
    .ctrl_hit_o(ctrl_hit),
    .ctrl_rd_o (ctrl_rd),
    .page_o    (page_o),
    .axi_en_o  (axi_pio_en_o),
    .pex_en_o  (pex_pio_en_o)
  );

  csr_reg_store #(
    .INT_W(INT_W), .WIN_W(WIN_W), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .DATA_W(DATA_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .int_off_i(int_off),
    .we_i     (store_wr),
    .be_i     (be),
    .wdata_i  (wdata_i),
    .rdata_o  (store_rd)
  );

  for (genvar b = 0; b < BE_W; b++) begin : g_rmask
    assign lane_mask[8*b +: 8] = {8{be[b]}};
  end

  assign rd_sel = (ctrl_hit ? ctrl_rd : store_rd) & lane_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i;
      err_q    <= req_i && !legal;
      rdata_q  <= (ok && !we_i) ? rd_sel : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;

  // R5
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i == 2'd2 && addr_i[1:0] != 2'b00 |=> err_o);
  // R5
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && size_i == 2'd3 |=> err_o);
  // R5
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  // R6
  rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  // R6
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o && !err_o);
endmodule

// File: tb/csr_page_decoder_test.sv
module csr_page_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o, err_o, axi_pio_en_o, pex_pio_en_o;
  logic [31:0] rdata_o;
  logic [5:0]  page_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_mem [256];
  logic [5:0]  m_page;
  logic [1:0]  m_en;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  csr_page_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i),
    .rvalid_o(rvalid_o), .err_o(err_o), .rdata_o(rdata_o),
    .page_o(page_o), .axi_pio_en_o(axi_pio_en_o), .pex_pio_en_o(pex_pio_en_o)
  );

  function automatic bit f_legal(logic [11:0] a, logic [1:0] s);
    if (s == 2'd3) return 1'b0;
    return (a & ((12'd1 << s) - 12'd1)) == 12'd0;
  endfunction

  function automatic logic [31:0] f_mask(logic [11:0] a, logic [1:0] s);
    logic [63:0] m;
    m = ((64'd1 << (8 << s)) - 64'd1) << (8 * (s == 2'd2 ? 0 : a[1:0]));
    return m[31:0];
  endfunction

  function automatic logic [15:0] f_int(logic [11:0] a, logic [5:0] p);
    return (a >= 12'hC00) ? {p, a[9:0]} : {4'h0, a};
  endfunction

  function automatic logic [7:0] f_idx(logic [15:0] o);
    return {o[11:10], o[7:2]};
  endfunction

  function automatic logic [31:0] f_ctrl();
    return {13'd0, m_page, 11'd0, m_en};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit we, logic [11:0] a, logic [1:0] s, logic [31:0] wd, string req);
    logic [31:0] exp_rd, m, c;
    bit lg, hit;
    logic [7:0] ix;
    lg  = f_legal(a, s);
    m   = f_mask(a, s);
    hit = (a[11:2] == 10'h202);
    ix  = f_idx(f_int(a, m_page));
    exp_rd = '0;
    if (lg && !we) exp_rd = (hit ? f_ctrl() : m_mem[ix]) & m;
    if (lg && we) begin
      if (hit) begin
        c = (f_ctrl() & ~m) | (wd & m);
        m_page = c[18:13];
        m_en   = c[1:0];
      end else begin
        m_mem[ix] = (m_mem[ix] & ~m) | (wd & m);
      end
    end
    req_i = 1'b1; we_i = we; addr_i = a; size_i = s; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    check(rvalid_o === 1'b1 && err_o === !lg && rdata_o === exp_rd &&
          page_o === m_page && {pex_pio_en_o, axi_pio_en_o} === m_en, req,
          {rvalid_o, err_o, page_o, pex_pio_en_o, axi_pio_en_o, rdata_o},
          {1'b1, !lg, m_page, m_en, exp_rd});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_page = '0;
    m_en = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7: reset state
    check(page_o === 6'd0 && axi_pio_en_o === 1'b0 && pex_pio_en_o === 1'b0 &&
          rvalid_o === 1'b0, "R7", {page_o, axi_pio_en_o, pex_pio_en_o}, 0);
    access(0, 12'h808, 2'd2, 0, "R7");
    // R2: control fields and ignored bits
    access(1, 12'h808, 2'd2, 32'hFFFF_FFFF, "R2");
    access(0, 12'h808, 2'd2, 0, "R2");
    access(0, 12'h80A, 2'd1, 0, "R2");
    // R1 / R3: direct and window reach the same word
    access(1, 12'h808, 2'd2, 32'h0000_2000, "R4");
    access(1, 12'hC10, 2'd2, 32'hA5A5_1234, "R3");
    access(0, 12'h410, 2'd2, 0, "R1");
    access(1, 12'h420, 2'd2, 32'h1111_2222, "R1");
    access(0, 12'hC20, 2'd2, 0, "R3");
    // R4: back-to-back page switch then windowed read
    access(1, 12'h808, 2'd2, 32'h0000_4000, "R4");
    access(0, 12'hC10, 2'd2, 0, "R4");
    access(1, 12'h809, 2'd0, 32'h0000_2000, "R4");
    access(0, 12'hC10, 2'd2, 0, "R4");
    // R5: misaligned and illegal size, including on the control word
    access(1, 12'h811, 2'd1, 32'hFFFF_FFFF, "R5");
    access(1, 12'h422, 2'd2, 32'hDEAD_BEEF, "R5");
    access(0, 12'h420, 2'd2, 0, "R5");
    access(1, 12'h80A, 2'd2, 32'hFFFF_FFFF, "R5");
    access(1, 12'h808, 2'd3, 32'hFFFF_FFFF, "R5");
    access(0, 12'h808, 2'd2, 0, "R5");
    access(0, 12'h421, 2'd1, 0, "R5");
    // R6: lanes
    access(1, 12'h103, 2'd0, 32'h7700_0000, "R6");
    access(1, 12'h102, 2'd1, 32'h0055_0000, "R6");
    access(0, 12'h100, 2'd2, 0, "R6");
    access(0, 12'h102, 2'd1, 0, "R6");
    access(0, 12'h101, 2'd0, 0, "R6");
    // R8: alias across bits outside 11:10 and 7:2
    access(0, 12'h120, 2'd2, 0, "R8");
    access(1, 12'h300, 2'd2, 32'hCAFE_0001, "R8");
    access(0, 12'h000, 2'd2, 0, "R8");
    @(negedge clk_i);
    // R6: idle gives no response
    check(rvalid_o === 1'b0 && err_o === 1'b0, "R6", {rvalid_o, err_o}, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [1:0] s;
      logic [31:0] d;
      bit w;
      a = 12'($urandom);
      s = 2'($urandom);
      d = $urandom;
      w = 1'($urandom);
      if (($urandom % 6) == 0) begin
        a = 12'h808 | 12'($urandom % 4);
        d = d & 32'h0007_E003;
      end else if (($urandom % 2) == 0) begin
        a = {2'b11, 2'($urandom), 8'($urandom)};
      end
      access(w, a, s, d, "R3");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule